// File: doc/BRIEF.md
# Zoned Data-Memory Wait-State Controller

This block sits between a processor core and a 14-bit data-memory address space. Every request the core presents is classified by address into one of three targets: an external zone, the on-chip RAM window, or the on-chip control region. Each external zone has its own programmable wait-state count. An external access drives a chip select plus a read or write strobe and is stretched by that zone's count. The core is stalled while the access is in progress.

The per-zone counts share a single configuration word that is itself reachable through ordinary data-memory reads and writes in the control region. The core holds its request while `stall` is high and may present the next request in the cycle after `stall` falls. Internal RAM and control-region accesses finish in the cycle they are presented. External data travels on the upper 16 lanes of a 24-lane bus, which is given here as separate in, out and enable vectors.

Top module: `dmem_wait_ctrl`

## Requirements
- R1: Address decode. External zone 0 is 0x0000–0x03FF, zone 1 is 0x0400–0x07FF and zone 2 is 0x0800–0x1FFF. Internal RAM is 0x2000–0x2FFF, and `intRamHit` is high in the cycle such a request is accepted. The control region is 0x3000–0x3FFF. `extAddr` carries the request address during an external access.
- R2: After reset, every zone's wait count is 7, the configuration word reads 0x01FF, and `extSel`, `extRd`, `extWr`, `stall` and `rdValid` are low.
- R3: An external access accepted in cycle 0 to a zone whose count is N holds `extSel` high, together with `extRd` (read) or `extWr` (write), in cycles 1 through N+1 and no others. `extAddr` stays constant throughout.
- R4: For an external access, `stall` is high in cycles 0 through N and low in cycle N+1, which is the final strobe cycle.
- R5: For an external read, bits [23:8] of `extDataIn` present in the final strobe cycle appear on `rdData` with `rdValid` high in the following cycle.
- R6: During external write strobe cycles, `extDataOut[23:8]` equals the write data and `extDataOe` is 0xFFFF00. At all other times `extDataOe` is zero. Bits [7:0] are never enabled.
- R7: The configuration word is at 0x3FFE. Zone i's count is held in bits [3i+2:3i]. Bits [15:9] read as zero. A write to it takes effect from the next access.
- R8: Control-region addresses other than 0x3FFE read as zero, and writes to them change nothing.
- R9: Internal RAM and control-region accesses never raise `stall`, `extSel` or the strobes. A control-region read returns its value with `rdValid` high in the next cycle.
- R10: A request is accepted only when no external access is in progress. Request inputs seen during an access are ignored. At least one cycle with `extSel` low separates two external accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Core presents a data-memory access |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 14 | Access address |
| reqWdata | input | 16 | Write data |
| stall | output | 1 | Core must hold its request |
| rdData | output | 16 | Read data (external or control region) |
| rdValid | output | 1 | rdData valid this cycle |
| intRamHit | output | 1 | Accepted access targets internal RAM |
| extSel | output | 1 | External data-memory chip select |
| extRd | output | 1 | External read strobe / output enable |
| extWr | output | 1 | External write strobe |
| extAddr | output | 14 | External address |
| extDataOut | output | 24 | External bus drive value |
| extDataOe | output | 24 | Per-lane drive enable for the external bus |
| extDataIn | input | 24 | External bus sampled value |

## Verification
Directed accesses land on the first and last word of each zone, each edge of the RAM window and each edge of the control region. These separate a wrong decode boundary from a wrong count. Configuration words with all counts zero, all counts maximal and distinct counts per zone show whether the stretch length follows the addressed zone, and whether it follows the latest write. A long access during which the request inputs are changed to a configuration write shows that busy-time input is ignored. Random mixes of reads, writes, zones and configuration updates, fed by random external bus data, cover the mix of back-to-back and interleaved targets.

// File: rtl/dmw_pkg.sv
package dmw_pkg;

  typedef enum logic [1:0] {
    RGN_EXT = 2'd0,
    RGN_RAM = 2'd1,
    RGN_CTL = 2'd2
  } region_e;

  // strobes from control to datapath
  typedef struct packed {
    logic launch;    // external access accepted this cycle
    logic finishRd;  // final cycle of an external read
    logic cfgWrite;  // write to the configuration word
    logic ctlRead;   // read from the control region
    logic cfgSel;    // current address is the configuration word
  } dpCtrl_t;

endpackage

// File: rtl/dmw_decode.sv
module dmw_decode
  import dmw_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int ZONES  = 3,
  parameter int ZIDX_W = 2,
  parameter logic [ZONES*ADDR_W-1:0] ZONE_ENDS = {14'h1FFF, 14'h07FF, 14'h03FF},
  parameter logic [ADDR_W-1:0] RAM_BASE = 14'h2000,
  parameter logic [ADDR_W-1:0] CTL_BASE = 14'h3000,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 14'h3FFE
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [ZIDX_W-1:0] zoneIdx,
  output logic              cfgHit
);

  logic [ZONES-1:0] zoneHit;

  for (genvar i = 0; i < ZONES; i++) begin : g_zone
    if (i == 0) begin : g_first
      assign zoneHit[i] = addr <= ZONE_ENDS[ADDR_W-1:0];
    end else begin : g_rest
      assign zoneHit[i] = (addr <= ZONE_ENDS[i*ADDR_W +: ADDR_W]) &&
                          (addr >  ZONE_ENDS[(i-1)*ADDR_W +: ADDR_W]);
    end
  end

  always_comb begin
    zoneIdx = '0;
    for (int i = 0; i < ZONES; i++) begin
      if (zoneHit[i]) zoneIdx = ZIDX_W'(i);
    end
  end

  always_comb begin
    if (addr < RAM_BASE)      region = RGN_EXT;
    else if (addr < CTL_BASE) region = RGN_RAM;
    else                      region = RGN_CTL;
  end

  assign cfgHit = (addr == CFG_ADDR);

endmodule

// File: rtl/dmw_ctrl.sv
module dmw_ctrl
  import dmw_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  region_e          region,
  input  logic             cfgHit,
  input  logic [CNT_W-1:0] waitSel,
  output logic             stall,
  output logic             extSel,
  output logic             extRd,
  output logic             extWr,
  output logic             intRamHit,
  output dpCtrl_t          dpCtrl
);

  localparam int MAX_RUN = 2 ** CNT_W;

  typedef enum logic {ST_IDLE, ST_ACT} state_e;

  state_e           state;
  logic [CNT_W-1:0] waitCnt;
  logic             writeQ;
  logic             accept;
  logic             lastCycle;

  assign accept    = reqValid && (state == ST_IDLE);
  assign lastCycle = (state == ST_ACT) && (waitCnt == '0);

  always_comb begin
    dpCtrl          = '0;
    dpCtrl.launch   = accept && (region == RGN_EXT);
    dpCtrl.finishRd = lastCycle && !writeQ;
    dpCtrl.cfgWrite = accept && (region == RGN_CTL) && reqWrite && cfgHit;
    dpCtrl.ctlRead  = accept && (region == RGN_CTL) && !reqWrite;
    dpCtrl.cfgSel   = cfgHit;
  end

  assign stall = (accept && (region == RGN_EXT)) ||
                 ((state == ST_ACT) && (waitCnt != '0));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      writeQ  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (dpCtrl.launch) begin
            state   <= ST_ACT;
            waitCnt <= waitSel;
            writeQ  <= reqWrite;
          end
        end
        default: begin
          if (lastCycle) state   <= ST_IDLE;
          else           waitCnt <= waitCnt - 1'b1;
        end
      endcase
    end
  end

  assign extSel    = (state == ST_ACT);
  assign extRd     = extSel && !writeQ;
  assign extWr     = extSel && writeQ;
  assign intRamHit = accept && (region == RGN_RAM);

  // length of the current select run, for the checker below
  logic [CNT_W:0] runLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       runLen <= '0;
    else if (extSel) runLen <= runLen + 1'b1;
    else             runLen <= '0;
  end

  p_run_len_r3: assert property (@(posedge clk) disable iff (!rstN)
    extSel |-> (runLen < (CNT_W+1)'(MAX_RUN)));

  p_final_drop_r4: assert property (@(posedge clk) disable iff (!rstN)
    (extSel && !stall) |=> !extSel);

  p_stall_keeps_sel_r4: assert property (@(posedge clk) disable iff (!rstN)
    (extSel && stall) |=> extSel);

  p_ram_nostall_r9: assert property (@(posedge clk) disable iff (!rstN)
    intRamHit |-> (!stall && !extSel));

  p_gap_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(extSel) |-> !extRd && !extWr);

endmodule

// File: rtl/dmw_datapath.sv
module dmw_datapath
  import dmw_pkg::*;
#(
  parameter int ADDR_W     = 14,
  parameter int DATA_W     = 16,
  parameter int BUS_W      = 24,
  parameter int ZONES      = 3,
  parameter int CNT_W      = 3,
  parameter int ZIDX_W     = 2,
  parameter int RESET_WAIT = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dpCtrl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [ZIDX_W-1:0] zoneIdx,
  input  logic              extSel,
  input  logic              extWr,
  input  logic [BUS_W-1:0]  extDataIn,
  output logic [CNT_W-1:0]  waitSel,
  output logic [ADDR_W-1:0] extAddr,
  output logic [BUS_W-1:0]  extDataOut,
  output logic [BUS_W-1:0]  extDataOe,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  localparam int CFG_W = ZONES * CNT_W;
  localparam int LOW_W = BUS_W - DATA_W;
  localparam logic [CFG_W-1:0] CFG_RESET = {ZONES{CNT_W'(RESET_WAIT)}};

  logic [CFG_W-1:0]  cfgReg;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic              unusedLowBits;

  assign unusedLowBits = ^extDataIn[LOW_W-1:0];

  always_comb begin
    waitSel = '0;
    for (int i = 0; i < ZONES; i++) begin
      if (zoneIdx == ZIDX_W'(i)) waitSel = cfgReg[i*CNT_W +: CNT_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cfgReg <= CFG_RESET;
    else if (dpCtrl.cfgWrite) cfgReg <= reqWdata[CFG_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
    end else if (dpCtrl.launch) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= dpCtrl.finishRd || dpCtrl.ctlRead;
      if (dpCtrl.finishRd)
        rdData <= extDataIn[BUS_W-1 -: DATA_W];
      else if (dpCtrl.ctlRead)
        rdData <= dpCtrl.cfgSel ? DATA_W'(cfgReg) : '0;
    end
  end

  assign extAddr    = addrQ;
  assign extDataOut = {wdataQ, {LOW_W{1'b0}}};
  assign extDataOe  = {{DATA_W{extWr}}, {LOW_W{1'b0}}};

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (extSel && $past(extSel)) |-> $stable(extAddr));

  p_wdata_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (extWr && $past(extWr)) |-> $stable(extDataOut));

  p_cfg_still_r8: assert property (@(posedge clk) disable iff (!rstN)
    extSel |=> $stable(cfgReg));

endmodule

// File: rtl/dmem_wait_ctrl.sv
module dmem_wait_ctrl
  import dmw_pkg::*;
#(
  parameter int ADDR_W     = 14,
  parameter int DATA_W     = 16,
  parameter int BUS_W      = 24,
  parameter int ZONES      = 3,
  parameter int CNT_W      = 3,
  parameter int RESET_WAIT = 7,
  parameter logic [ZONES*ADDR_W-1:0] ZONE_ENDS = {14'h1FFF, 14'h07FF, 14'h03FF},
  parameter logic [ADDR_W-1:0] RAM_BASE = 14'h2000,
  parameter logic [ADDR_W-1:0] CTL_BASE = 14'h3000,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 14'h3FFE
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              stall,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              intRamHit,
  output logic              extSel,
  output logic              extRd,
  output logic              extWr,
  output logic [ADDR_W-1:0] extAddr,
  output logic [BUS_W-1:0]  extDataOut,
  output logic [BUS_W-1:0]  extDataOe,
  input  logic [BUS_W-1:0]  extDataIn
);

  localparam int ZIDX_W = (ZONES > 1) ? $clog2(ZONES) : 1;

  region_e           region;
  logic [ZIDX_W-1:0] zoneIdx;
  logic              cfgHit;
  logic [CNT_W-1:0]  waitSel;
  dpCtrl_t           dpCtrl;

  dmw_decode #(
    .ADDR_W(ADDR_W), .ZONES(ZONES), .ZIDX_W(ZIDX_W), .ZONE_ENDS(ZONE_ENDS),
    .RAM_BASE(RAM_BASE), .CTL_BASE(CTL_BASE), .CFG_ADDR(CFG_ADDR)
  ) i_decode (
    .addr(reqAddr), .region(region), .zoneIdx(zoneIdx), .cfgHit(cfgHit)
  );

  dmw_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .region(region), .cfgHit(cfgHit), .waitSel(waitSel), .stall(stall),
    .extSel(extSel), .extRd(extRd), .extWr(extWr), .intRamHit(intRamHit),
    .dpCtrl(dpCtrl)
  );

  dmw_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUS_W(BUS_W), .ZONES(ZONES),
    .CNT_W(CNT_W), .ZIDX_W(ZIDX_W), .RESET_WAIT(RESET_WAIT)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .dpCtrl(dpCtrl), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .zoneIdx(zoneIdx), .extSel(extSel), .extWr(extWr),
    .extDataIn(extDataIn), .waitSel(waitSel), .extAddr(extAddr),
    .extDataOut(extDataOut), .extDataOe(extDataOe), .rdData(rdData),
    .rdValid(rdValid)
  );

  p_rd_wr_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(extRd && extWr));

  p_oe_only_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    (extDataOe != '0) |-> (extWr && extSel));

endmodule

// File: tb/test_dmem_wait_ctrl.sv
module test_dmem_wait_ctrl;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqWrite;
  logic [13:0] reqAddr;
  logic [15:0] reqWdata;
  logic        stall, rdValid, intRamHit, extSel, extRd, extWr;
  logic [15:0] rdData;
  logic [13:0] extAddr;
  logic [23:0] extDataOut, extDataOe, extDataIn;

  int compared = 0;
  int mismatched = 0;
  logic [15:0] mCfg;
  localparam logic [13:0] CFG = 14'h3FFE;

  always #4 clk = ~clk;

  dmem_wait_ctrl i_dmem_wait_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .stall(stall), .rdData(rdData),
    .rdValid(rdValid), .intRamHit(intRamHit), .extSel(extSel), .extRd(extRd),
    .extWr(extWr), .extAddr(extAddr), .extDataOut(extDataOut),
    .extDataOe(extDataOe), .extDataIn(extDataIn)
  );

  task automatic chk(bit ok, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // zone index, -1 for RAM window, -2 for control region
  function automatic int zoneOf(logic [13:0] a);
    if (a <= 14'h03FF) return 0;
    if (a <= 14'h07FF) return 1;
    if (a <  14'h2000) return 2;
    if (a <  14'h3000) return -1;
    return -2;
  endfunction

  function automatic int waitOf(int z);
    return int'((mCfg >> (3 * z)) & 16'h7);
  endfunction

  function automatic logic [15:0] ctlValue(logic [13:0] a);
    return (a == CFG) ? (mCfg & 16'h01FF) : 16'h0000;
  endfunction

  // called at a falling edge; returns at a falling edge with reqValid low
  task automatic doAcc(bit w, logic [13:0] a, logic [15:0] d, bit disturb);
    int z = zoneOf(a);
    int n;
    logic [15:0] lastIn = '0;
    logic [15:0] expCtl;
    reqValid = 1'b1; reqWrite = w; reqAddr = a; reqWdata = d;
    #1;
    if (z >= 0) begin
      n = waitOf(z);
      chk(stall === 1'b1, "R4 stall in accept cycle", stall, 1);
      chk(intRamHit === 1'b0, "R1 no RAM hit for external", intRamHit, 0);
      for (int j = 1; j <= n + 1; j++) begin
        @(negedge clk);
        chk(extSel === 1'b1, "R3 select held", extSel, 1);
        chk(extRd === !w && extWr === w, "R3 strobe kind", {extRd, extWr}, {!w, w});
        chk(extAddr === a, "R1 external address", extAddr, a);
        chk(stall === (j <= n), "R4 stall per cycle", stall, (j <= n));
        chk(extDataOe === (w ? 24'hFFFF00 : 24'h0), "R6 drive enable", extDataOe,
            w ? 24'hFFFF00 : 24'h0);
        if (w) chk(extDataOut[23:8] === d, "R6 write data", extDataOut[23:8], d);
        extDataIn = 24'($urandom);
        lastIn = extDataIn[23:8];
        if (disturb) begin
          reqWrite = 1'b1; reqAddr = CFG; reqWdata = 16'h0000;
        end
      end
      @(negedge clk);
      reqValid = 1'b0;
      chk(extSel === 1'b0 && extRd === 1'b0 && extWr === 1'b0, "R10 strobe gap", extSel, 0);
      chk(rdValid === !w, "R5 read valid", rdValid, !w);
      if (!w) chk(rdData === lastIn, "R5 read data", rdData, lastIn);
    end else begin
      expCtl = ctlValue(a);
      chk(stall === 1'b0, "R9 no stall internal", stall, 0);
      chk(intRamHit === (z == -1), "R1 RAM hit", intRamHit, (z == -1));
      if (w && a == CFG) mCfg = d & 16'h01FF;
      @(negedge clk);
      reqValid = 1'b0;
      chk(extSel === 1'b0 && extDataOe === 24'h0, "R9 no external activity", extSel, 0);
      chk(rdValid === (z == -2 && !w), "R9 control read valid", rdValid, (z == -2 && !w));
      if (z == -2 && !w) chk(rdData === expCtl, "R8 control read value", rdData, expCtl);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [13:0] a;
    int k;
    void'($urandom(32'd5113));
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqAddr = '0; reqWdata = '0;
    extDataIn = '0;
    mCfg = 16'h01FF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk({extSel, extRd, extWr, stall, rdValid} === 5'b0, "R2 idle after reset",
        {extSel, extRd, extWr, stall, rdValid}, 0);
    doAcc(0, CFG, 0, 0);                       // R2 / R7 reset word
    // R1 zone boundaries at reset counts (R2: all 7)
    doAcc(0, 14'h0000, 0, 0); doAcc(1, 14'h03FF, 16'hA5C3, 0);
    doAcc(0, 14'h0400, 0, 0); doAcc(0, 14'h07FF, 0, 0);
    doAcc(1, 14'h0800, 16'h1234, 0); doAcc(0, 14'h1FFF, 0, 0);
    // R7 all counts zero
    doAcc(1, CFG, 16'h0000, 0);
    doAcc(0, 14'h0010, 0, 0); doAcc(1, 14'h0500, 16'hBEEF, 0); doAcc(0, 14'h1000, 0, 0);
    // R7 upper bits read zero
    doAcc(1, CFG, 16'hFFFF, 0); doAcc(0, CFG, 0, 0);
    // R7 distinct counts: zone0=1 zone1=4 zone2=2
    doAcc(1, CFG, 16'h00A1, 0);
    doAcc(0, 14'h0001, 0, 0); doAcc(1, 14'h0401, 16'h0F0F, 0); doAcc(0, 14'h0801, 0, 0);
    // R8 other control addresses
    doAcc(1, 14'h3000, 16'hFFFF, 0); doAcc(0, 14'h3000, 0, 0);
    doAcc(1, 14'h3FFF, 16'h0000, 0); doAcc(0, 14'h3FFF, 0, 0); doAcc(0, 14'h3FFD, 0, 0);
    doAcc(0, CFG, 0, 0);
    // R9 internal RAM edges
    doAcc(0, 14'h2000, 0, 0); doAcc(1, 14'h2FFF, 16'h7777, 0);
    // R10 busy-time inputs ignored
    doAcc(0, 14'h0600, 0, 1); doAcc(0, CFG, 0, 0);
    // random mix
    for (int i = 0; i < 200; i++) begin
      k = $urandom_range(0, 7);
      case (k)
        0, 1, 2, 3: a = 14'($urandom_range(0, 16'h1FFF));
        4:          a = 14'($urandom_range(16'h2000, 16'h2FFF));
        5:          a = CFG;
        6:          a = 14'($urandom_range(16'h3000, 16'h3FFD));
        default:    a = (i % 2 == 0) ? 14'h03FF : 14'h0400;
      endcase
      doAcc(1'($urandom), a, 16'($urandom), ($urandom_range(0, 5) == 0));
      if ($urandom_range(0, 3) == 0) @(negedge clk);
    end
    summary();
  end

endmodule